// File: doc/BRIEF.md
# Cartridge Bank Register Mapper

This block sits between an 8-bit CPU, its video fetch bus and the two ROM arrays of a game cartridge. It watches CPU write cycles and catches those whose address falls on one of its decode patterns. From those writes it keeps four program bank numbers, eight character bank numbers and a nametable mirroring mode. One program bank number is taken from the address lines of the write, not from the data bus. Each character bank number is built from two separate 4-bit writes.

CPU reads in 0x6000–0x7FFF and 0x8000–0xFFFF are translated into program ROM addresses in 8 KiB windows. The top window always points at the last bank. Video reads below 0x2000 are translated into character ROM addresses in 1 KiB windows. Bank numbers are masked to the ROM sizes set by parameters. Both parameters must be powers of two between 2 and 256. The translation paths are combinational. Register updates take effect on the clock edge that samples the write strobe.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset all program banks, all character banks and the mirroring mode are 0, so CPU address 0x8000 translates to program ROM address 0 and `mirror_o` is 0.
- R2: A write with address bits [15:11] = 01101 (0x6800–0x6FFF) loads program bank 3 with address bits [5:0], zero-extended. The data bus is ignored.
- R3: A write whose address ANDed with 0xF80C equals 0x8800, 0xA800 or 0xA000 loads program bank 0, 1 or 2 with the full 8-bit data byte.
- R4: A CPU read in 0x6000–0x7FFF uses bank 3. Reads in 0x8000, 0xA000 and 0xC000 use banks 0, 1 and 2. A read in 0xE000–0xFFFF uses bank PRG_BANKS−1.
- R5: The program bank is ANDed with PRG_BANKS−1, and the output is bank·2^13 + addr[12:0]. For a CPU address below 0x6000 the output is 0.
- R6: A write whose address ANDed with 0xF80C lies in 0xB000..0xE00C inclusive targets character bank (((addr>>11) − 6) | (addr>>3)) & 7.
- R7: In a character write, address bit 2 = 0 replaces bits [3:0] of the bank with data[3:0], and address bit 2 = 1 replaces bits [7:4] with data[3:0]. The other nibble and data[7:4] have no effect.
- R8: A write whose address ANDed with 0xF80C equals 0x9800 sets `mirror_o` to data[1:0]: 0 vertical, 1 horizontal, 2 single-screen A, 3 single-screen B.
- R9: A video read below 0x2000 uses character bank addr[12:10], ANDed with CHR_BANKS−1, and the output is bank·2^10 + addr[9:0]. For a video address at or above 0x2000 the output is 0.
- R10: Decode priority is the 0x6800 range, then the character range, then the single registers. Writes that match no pattern, and cycles with `cpu_we_i` low, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, one write per cycle while high |
| ppu_addr_i | input | 14 | Video bus address |
| prg_rom_addr_o | output | $clog2(PRG_BANKS)+13 | Program ROM address |
| chr_rom_addr_o | output | $clog2(CHR_BANKS)+10 | Character ROM address |
| mirror_o | output | 2 | Nametable mirroring mode |

## Verification
The assertions assume that `cpu_we_i` is known in every cycle after reset. They also assume that a write is applied for exactly one clock with a stable address and data, so that the register values seen in the following cycle belong to that write alone. The bench drives every input at the falling edge and holds it until the next falling edge, so every rising edge samples one settled write or idle cycle. The random phase draws addresses from the decode bases with random alias bits, so the aliased and unmatched patterns are reached on purpose.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [2:0] {
    WR_NONE,
    WR_ADDR_BANK,
    WR_CHR,
    WR_PRG,
    WR_MIRROR
  } wr_kind_e;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  localparam int unsigned BANK_W = 8;
  localparam int unsigned NUM_PRG = 4;
  localparam int unsigned NUM_CHR = 8;
endpackage

// File: rtl/bmc_wr_decode.sv
module bmc_wr_decode
  import bmc_pkg::*;
(
  input  logic [15:0] addr_i,
  input  logic        we_i,
  output wr_kind_e    kind_o,
  output logic [1:0]  prg_sel_o,
  output logic [2:0]  chr_sel_o,
  output logic        hi_nib_o
);
  logic [15:0] masked;
  logic        in_addr_bank, in_chr;
  logic        unused_bits;

  assign masked       = addr_i & 16'hF80C;
  assign in_addr_bank = (addr_i[15:11] == 5'b01101);
  assign in_chr       = (masked >= 16'hB000) && (masked <= 16'hE00C);
  assign chr_sel_o    = (addr_i[13:11] - 3'd6) | addr_i[5:3];
  assign hi_nib_o     = addr_i[2];
  assign unused_bits  = ^{addr_i[10:6], addr_i[1:0]};

  always_comb begin
    kind_o    = WR_NONE;
    prg_sel_o = 2'd0;
    if (we_i) begin
      if (in_addr_bank) begin
        kind_o    = WR_ADDR_BANK;
        prg_sel_o = 2'd3;
      end else if (in_chr) begin
        kind_o = WR_CHR;
      end else begin
        unique case (masked)
          16'h8800: begin kind_o = WR_PRG; prg_sel_o = 2'd0; end
          16'hA800: begin kind_o = WR_PRG; prg_sel_o = 2'd1; end
          16'hA000: begin kind_o = WR_PRG; prg_sel_o = 2'd2; end
          16'h9800: kind_o = WR_MIRROR;
          default:  kind_o = WR_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmc_bank_regs.sv
module bmc_bank_regs
  import bmc_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  wr_kind_e                          kind_i,
  input  logic [1:0]                        prg_sel_i,
  input  logic [2:0]                        chr_sel_i,
  input  logic                              hi_nib_i,
  input  logic [5:0]                        addr_lo_i,
  input  logic [7:0]                        data_i,
  output logic [NUM_PRG-1:0][BANK_W-1:0]    prg_bank_o,
  output logic [NUM_CHR-1:0][BANK_W-1:0]    chr_bank_o,
  output logic [1:0]                        mirror_o
);
  for (genvar g = 0; g < NUM_PRG; g++) begin : g_prg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prg_bank_o[g] <= '0;
      end else if (prg_sel_i == 2'(g)) begin
        if (kind_i == WR_ADDR_BANK) prg_bank_o[g] <= {2'b00, addr_lo_i};
        else if (kind_i == WR_PRG)  prg_bank_o[g] <= data_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_CHR; g++) begin : g_chr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chr_bank_o[g] <= '0;
      end else if (kind_i == WR_CHR && chr_sel_i == 3'(g)) begin
        if (hi_nib_i) chr_bank_o[g][7:4] <= data_i[3:0];
        else          chr_bank_o[g][3:0] <= data_i[3:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mirror_o <= MIR_VERT;
    else if (kind_i == WR_MIRROR) mirror_o <= data_i[1:0];
  end
endmodule

// File: rtl/bmc_prg_xlate.sv
module bmc_prg_xlate
  import bmc_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32,
  localparam int unsigned PRG_BW = $clog2(PRG_BANKS),
  localparam int unsigned PRG_AW = PRG_BW + 13
) (
  input  logic [15:0]                     addr_i,
  input  logic [NUM_PRG-1:0][BANK_W-1:0]  prg_bank_i,
  output logic [PRG_AW-1:0]               rom_addr_o
);
  localparam logic [BANK_W-1:0] PRG_MASK = BANK_W'(PRG_BANKS - 1);

  logic [BANK_W-1:0] bank, bank_m;
  logic              hit;

  always_comb begin
    hit  = 1'b1;
    bank = '0;
    unique case (addr_i[15:13])
      3'd3:    bank = prg_bank_i[3];
      3'd4:    bank = prg_bank_i[0];
      3'd5:    bank = prg_bank_i[1];
      3'd6:    bank = prg_bank_i[2];
      3'd7:    bank = '1;
      default: hit  = 1'b0;
    endcase
  end

  assign bank_m     = bank & PRG_MASK;
  assign rom_addr_o = hit ? {bank_m[PRG_BW-1:0], addr_i[12:0]} : '0;
endmodule

// File: rtl/bmc_chr_xlate.sv
module bmc_chr_xlate
  import bmc_pkg::*;
#(
  parameter int unsigned CHR_BANKS = 256,
  localparam int unsigned CHR_BW = $clog2(CHR_BANKS),
  localparam int unsigned CHR_AW = CHR_BW + 10
) (
  input  logic [13:0]                     addr_i,
  input  logic [NUM_CHR-1:0][BANK_W-1:0]  chr_bank_i,
  output logic [CHR_AW-1:0]               rom_addr_o
);
  localparam logic [BANK_W-1:0] CHR_MASK = BANK_W'(CHR_BANKS - 1);

  logic [BANK_W-1:0] bank_m;

  assign bank_m     = chr_bank_i[addr_i[12:10]] & CHR_MASK;
  assign rom_addr_o = addr_i[13] ? '0 : {bank_m[CHR_BW-1:0], addr_i[9:0]};
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bmc_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32,
  parameter int unsigned CHR_BANKS = 256,
  localparam int unsigned PRG_AW = $clog2(PRG_BANKS) + 13,
  localparam int unsigned CHR_AW = $clog2(CHR_BANKS) + 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_we_i,
  input  logic [13:0]       ppu_addr_i,
  output logic [PRG_AW-1:0] prg_rom_addr_o,
  output logic [CHR_AW-1:0] chr_rom_addr_o,
  output logic [1:0]        mirror_o
);
  wr_kind_e                        wr_kind;
  logic [1:0]                      prg_sel;
  logic [2:0]                      chr_sel;
  logic                            hi_nib;
  logic [NUM_PRG-1:0][BANK_W-1:0]  prg_bank_q;
  logic [NUM_CHR-1:0][BANK_W-1:0]  chr_bank_q;

  bmc_wr_decode u_dec (
    .addr_i    (cpu_addr_i),
    .we_i      (cpu_we_i),
    .kind_o    (wr_kind),
    .prg_sel_o (prg_sel),
    .chr_sel_o (chr_sel),
    .hi_nib_o  (hi_nib)
  );

  bmc_bank_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (wr_kind),
    .prg_sel_i  (prg_sel),
    .chr_sel_i  (chr_sel),
    .hi_nib_i   (hi_nib),
    .addr_lo_i  (cpu_addr_i[5:0]),
    .data_i     (cpu_data_i),
    .prg_bank_o (prg_bank_q),
    .chr_bank_o (chr_bank_q),
    .mirror_o   (mirror_o)
  );

  bmc_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .addr_i     (cpu_addr_i),
    .prg_bank_i (prg_bank_q),
    .rom_addr_o (prg_rom_addr_o)
  );

  bmc_chr_xlate #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .addr_i     (ppu_addr_i),
    .chr_bank_i (chr_bank_q),
    .rom_addr_o (chr_rom_addr_o)
  );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker
  import bmc_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 32,
  parameter int unsigned CHR_BANKS = 256,
  localparam int unsigned PRG_BW = $clog2(PRG_BANKS),
  localparam int unsigned PRG_AW = PRG_BW + 13,
  localparam int unsigned CHR_AW = $clog2(CHR_BANKS) + 10
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [15:0]                      cpu_addr_i,
  input logic [7:0]                       cpu_data_i,
  input logic                             cpu_we_i,
  input logic [13:0]                      ppu_addr_i,
  input logic [PRG_AW-1:0]                prg_rom_addr_o,
  input logic [CHR_AW-1:0]                chr_rom_addr_o,
  input logic [1:0]                       mirror_o,
  input logic [NUM_PRG-1:0][BANK_W-1:0]   prg_bank,
  input logic [NUM_CHR-1:0][BANK_W-1:0]   chr_bank
);
  logic [15:0] masked;
  logic        unused_ppu;
  assign masked     = cpu_addr_i & 16'hF80C;
  assign unused_ppu = ^ppu_addr_i[12:0];

  p_addr_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && cpu_addr_i[15:11] == 5'b01101 |=> prg_bank[3] == {2'b00, $past(cpu_addr_i[5:0])});

  p_prg_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && masked == 16'h8800 |=> prg_bank[0] == $past(cpu_data_i));

  p_top_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:13] == 3'd7 |-> prg_rom_addr_o[PRG_AW-1:13] == PRG_BW'(PRG_BANKS - 1));

  p_low_cpu_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i < 16'h6000 |-> prg_rom_addr_o == '0);

  p_mirror_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && masked == 16'h9800 |=> mirror_o == $past(cpu_data_i[1:0]));

  p_chr_high_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppu_addr_i[13] |-> chr_rom_addr_o == '0);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_we_i |=> $stable(prg_bank) && $stable(chr_bank) && $stable(mirror_o));

  p_unmatched_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && masked == 16'hF000 |=> $stable(prg_bank) && $stable(chr_bank) && $stable(mirror_o));
endmodule

bind bank_map_ctrl bmc_checker #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_bmc_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_addr_i     (cpu_addr_i),
  .cpu_data_i     (cpu_data_i),
  .cpu_we_i       (cpu_we_i),
  .ppu_addr_i     (ppu_addr_i),
  .prg_rom_addr_o (prg_rom_addr_o),
  .chr_rom_addr_o (chr_rom_addr_o),
  .mirror_o       (mirror_o),
  .prg_bank       (prg_bank_q),
  .chr_bank       (chr_bank_q)
);

// File: tb/bank_map_ctrl_bench.sv
`timescale 1ns/1ps
module bank_map_ctrl_bench;
  localparam int PRG_BANKS = 16;
  localparam int CHR_BANKS = 128;
  localparam int PRG_AW = $clog2(PRG_BANKS) + 13;
  localparam int CHR_AW = $clog2(CHR_BANKS) + 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [15:0]       cpu_addr_i = '0;
  logic [7:0]        cpu_data_i = '0;
  logic              cpu_we_i = 1'b0;
  logic [13:0]       ppu_addr_i = '0;
  logic [PRG_AW-1:0] prg_rom_addr_o;
  logic [CHR_AW-1:0] chr_rom_addr_o;
  logic [1:0]        mirror_o;

  int n_vec = 0;
  int n_bad = 0;
  int m_prg[4];
  int m_chr[8];
  int m_mir;

  always #2 clk_i = ~clk_i;

  bank_map_ctrl #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_bank_map_ctrl (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i, .ppu_addr_i,
    .prg_rom_addr_o, .chr_rom_addr_o, .mirror_o
  );

  function automatic int exp_prg(int a);
    int w, b;
    w = a >> 13;
    case (w)
      3: b = m_prg[3];
      4: b = m_prg[0];
      5: b = m_prg[1];
      6: b = m_prg[2];
      7: b = 255;
      default: return 0;
    endcase
    b = b & (PRG_BANKS - 1);
    return (b << 13) | (a & 'h1FFF);
  endfunction

  function automatic int exp_chr(int a);
    int b;
    if (a >= 'h2000) return 0;
    b = m_chr[(a >> 10) & 7] & (CHR_BANKS - 1);
    return (b << 10) | (a & 'h3FF);
  endfunction

  task automatic model_write(int a, int d);
    int mk, idx;
    mk = a & 'hF80C;
    if ((a & 'hF800) == 'h6800) m_prg[3] = a & 'h3F;
    else if (mk >= 'hB000 && mk <= 'hE00C) begin
      idx = (((a >> 11) - 6) | (a >> 3)) & 7;
      if ((a & 4) != 0) m_chr[idx] = (m_chr[idx] & 'h0F) | ((d & 'hF) << 4);
      else              m_chr[idx] = (m_chr[idx] & 'hF0) | (d & 'hF);
    end else if (mk == 'h8800) m_prg[0] = d;
    else if (mk == 'hA800) m_prg[1] = d;
    else if (mk == 'hA000) m_prg[2] = d;
    else if (mk == 'h9800) m_mir = d & 3;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare comb outputs, then the write lands at the next posedge
  task automatic step(int a, int d, bit we, int v, string tag);
    @(negedge clk_i);
    cpu_addr_i = 16'(a);
    cpu_data_i = 8'(d);
    cpu_we_i   = we;
    ppu_addr_i = 14'(v);
    #1;
    chk(tag, "prg_addr", int'(prg_rom_addr_o), exp_prg(a));
    chk(tag, "chr_addr", int'(chr_rom_addr_o), exp_chr(v));
    chk(tag, "mirror", int'(mirror_o), m_mir);
    if (we) model_write(a, d);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int chr_base[8];
    int bases[12];
    for (int i = 0; i < 4; i++) m_prg[i] = 0;
    for (int i = 0; i < 8; i++) m_chr[i] = 0;
    m_mir = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    step('h8000, 0, 0, 'h0000, "R1");
    step('h6123, 0, 0, 'h1FFF, "R1");
    step('hC456, 0, 0, 'h0C00, "R1");

    // R2: address-sourced bank, data ignored
    step('h682A, 'hFF, 1, 0, "R2");
    step('h6010, 0, 0, 0, "R2");
    step('h6FC5, 'h00, 1, 0, "R2");
    step('h7ABC, 0, 0, 0, "R2");
    step('h7005, 'h33, 1, 0, "R2");
    step('h6000, 0, 0, 0, "R2");

    // R3 / R4: program banks and windows, with alias bits
    step('h8800, 'h05, 1, 0, "R3");
    step('hA800, 'h09, 1, 0, "R3");
    step('hABF3, 'h0C, 1, 0, "R3");
    step('hA000, 'h07, 1, 0, "R3");
    step('h8001, 0, 0, 0, "R4");
    step('hA002, 0, 0, 0, "R4");
    step('hC003, 0, 0, 0, "R4");
    step('hE004, 0, 0, 0, "R4");
    step('hFFFF, 0, 0, 0, "R4");

    // R5: masking and low range
    step('h8BF3, 'hFF, 1, 0, "R5");
    step('h9ABC, 0, 0, 0, "R5");
    step('h4000, 0, 0, 0, "R5");
    step('h5FFF, 0, 0, 0, "R5");

    // R6 / R7: every character bank, both nibbles, then readback
    chr_base = '{'hB000, 'hB008, 'hC000, 'hC008, 'hD000, 'hD008, 'hE000, 'hE008};
    for (int i = 0; i < 8; i++) begin
      step(chr_base[i], 'hA0 | (i + 3), 1, 0, "R7");
      step(chr_base[i] | 4, 'h50 | (7 - i), 1, 0, "R7");
    end
    for (int i = 0; i < 8; i++) step('h0000, 0, 0, (i << 10) | 'h155, "R6");
    step('hB83C, 'h0E, 1, 0, "R6");
    step('hE00C, 'h01, 1, 0, "R6");
    for (int i = 0; i < 8; i++) step('h0000, 0, 0, (i << 10) | 'h2AA, "R9");
    step('h0000, 0, 0, 'h2000, "R9");
    step('h0000, 0, 0, 'h3FFF, "R9");

    // R8: mirroring modes
    for (int i = 0; i < 4; i++) step('h9BF0, 'hFC | i, 1, 0, "R8");
    step('h9800, 'h01, 1, 0, "R8");
    step('h8000, 0, 0, 0, "R8");

    // R10: unmatched writes and idle strobes
    step('h980C, 'h03, 1, 0, "R10");
    step('hF000, 'hFF, 1, 0, "R10");
    step('hF008, 'h07, 1, 0, "R10");
    step('h8804, 'h0B, 1, 0, "R10");
    step('h8800, 'h02, 0, 0, "R10");
    step('hB000, 'h0F, 0, 0, "R10");
    step('h6800, 'h00, 0, 0, "R10");
    step('h8000, 0, 0, 'h0000, "R10");

    // mixed traffic around the decode bases
    bases = '{'h6800, 'h8800, 'hA800, 'hA000, 'h9800, 'hB000, 'hC000,
              'hD000, 'hE000, 'hF000, 'h7000, 'h0000};
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = bases[$urandom_range(0, 11)] | int'($urandom_range(0, 'h7FF));
      if ($urandom_range(0, 2) == 0) a = int'($urandom_range(0, 'hFFFF));
      step(a, int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 'h3FFF)), "R10");
    end

    summary();
    $finish;
  end
endmodule